// File: doc/BRIEF.md
# Chaining DMA descriptor engine

This block sequences a scatter-gather DMA run from a table of descriptors held in host memory. Software writes a short header: first the byte address of the table, then the number of descriptors. The write of the count launches the run. The engine then works through the table without further help from software. For each entry it issues a read request and gathers the four returned dwords. It hands length, source, destination and control bits to an external data mover through a start/done handshake. It then advances to the next 16-byte slot. The data movers themselves sit outside this block. One instance serves one direction, so a read mover and a write mover each get their own engine and can run together.

A free-standing cycle counter times each run. It clears on the launching header write and counts every clock until the run's final descriptor completes. The first descriptor fetch is therefore part of the measured time. A control bit in each descriptor can request a notification pulse, and another can end the chain early. A header write that arrives while a run is active changes nothing, but it latches a sticky error flag.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, stat_busy, stat_err, dfetch_req, xfer_start and irq are 0 and stat_cycles is 0.
- R2: A write with reg_sel=0 sets the table base, with reg_wdata bits 3:0 forced to zero. A write with reg_sel=1 and a nonzero count in reg_wdata[15:0] launches a run while idle, and stat_busy is 1 from the next cycle. A count of zero starts nothing.
- R3: The k-th descriptor of a run (k from 0) is requested at base+16*k. dfetch_req and dfetch_addr hold until dfetch_ack. The request is followed by four dret_valid beats, dword0 to dword3 in order.
- R4: Descriptor layout: dword0[15:0] is the length in dwords, dword0[31:16] is the control field, dword1 is the source address, dword2 is the destination address, and dword3 is unused. A nonzero length produces a one-cycle xfer_start that carries these fields.
- R5: Descriptors run strictly one at a time. No new fetch is requested while a started transfer has not returned xfer_done.
- R6: A descriptor of length 0 produces no xfer_start and counts as complete as soon as its fourth dword arrives.
- R7: Control bit 1 (end of chain) ends the run after that descriptor, even when the count has not been used up.
- R8: Control bit 0 (notify) gives a one-cycle irq pulse in the cycle after that descriptor completes. A descriptor with this bit clear gives no pulse.
- R9: A run ends after the programmed number of descriptors. stat_busy falls at the clock edge of the final completion.
- R10: stat_cycles is cleared by the launching write. It increments on every edge up to and including the final completion edge, and then holds.
- R11: A reg_sel=0 or reg_sel=1 write while busy is ignored and sets stat_err. stat_err stays set until a reg_sel=2 write with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 count/launch, 2 error clear |
| reg_wdata | input | 32 | Register write data |
| dfetch_req | output | 1 | Descriptor read request |
| dfetch_addr | output | 32 | Byte address of the requested descriptor |
| dfetch_ack | input | 1 | Request accepted |
| dret_valid | input | 1 | Returned descriptor dword valid |
| dret_data | input | 32 | Returned descriptor dword |
| xfer_start | output | 1 | One-cycle transfer launch to the data mover |
| xfer_len | output | 16 | Transfer length in dwords |
| xfer_ctrl | output | 16 | Descriptor control field |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_done | input | 1 | Data mover finished the current transfer |
| irq | output | 1 | Notification pulse |
| stat_busy | output | 1 | Run in progress |
| stat_err | output | 1 | Sticky header-while-busy error |
| stat_cycles | output | 32 | Cycle count of the current or last run |

## Verification
The results are due at these points:
- A launching write shows stat_busy and dfetch_req in the cycle after its edge.
- xfer_start appears in the cycle after the edge that follows the fourth returned dword.
- irq appears in the cycle after a completion edge.
- stat_busy falls, and stat_cycles takes its final value, at the edge that samples the last xfer_done.

The bench drives every input on falling edges and samples outputs on falling edges. It takes the expected run length from its own edge counter, as the number of edges between the launching edge and the first falling edge with stat_busy low. It waits a few spare cycles before comparing the per-run tallies of fetches, starts and pulses.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int DW         = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * (DW / 8);
  localparam int ALIGN_W    = $clog2(DESC_BYTES);
  localparam int USED_WORDS = 3;
  localparam int LEN_W      = 16;
  localparam int CTL_W      = DW - LEN_W;
  localparam int CTL_NOTIFY = 0;
  localparam int CTL_LAST   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RECV,
    ST_START,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctrl;
    logic [LEN_W-1:0] len;
    logic [DW-1:0]    src;
    logic [DW-1:0]    dst;
  } desc_t;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             busy,
  output logic             launch,
  output logic [CNT_W-1:0] count,
  output logic [DW-1:0]    base,
  output logic             err
);
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  logic          hdr_wr;
  logic          base_en;
  logic [DW-1:0] base_d;
  logic          err_d;

  always_comb begin
    hdr_wr  = reg_wr && ((reg_sel == SEL_BASE) || (reg_sel == SEL_CNT));
    count   = reg_wdata[CNT_W-1:0];
    launch  = reg_wr && (reg_sel == SEL_CNT) && !busy && (count != '0);
    base_en = reg_wr && (reg_sel == SEL_BASE) && !busy;
    base_d  = {reg_wdata[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
    err_d   = err;
    if (hdr_wr && busy) begin
      err_d = 1'b1;
    end else if (reg_wr && (reg_sel == SEL_CLR) && reg_wdata[0]) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else if (base_en) begin
      base <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else begin
      err <= err_d;
    end
  end

  // R11: the error flag only rises after a header write that hit a busy engine
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(reg_wr && busy && (reg_sel != SEL_CLR) && (reg_sel != 2'd3)))
    else $error("error flag rose without a busy header write");

  // R11: a base write during a run leaves the stored base alone
  assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_sel == SEL_BASE)) |=> $stable(base))
    else $error("base changed during a run");
endmodule

// File: rtl/chain_dma_fetch.sv
module chain_dma_fetch
  import chain_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dret_valid,
  input  logic [DW-1:0] dret_data,
  output logic          desc_valid,
  output desc_t         desc
);
  localparam int BEAT_W = $clog2(DESC_WORDS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DESC_WORDS - 1);

  logic [BEAT_W-1:0]              beat_q;
  logic [BEAT_W-1:0]              beat_d;
  logic                           take;
  logic                           vld_d;
  logic [USED_WORDS-1:0][DW-1:0]  words;

  always_comb begin
    take = en && dret_valid;
    if (!en) begin
      beat_d = '0;
    end else if (take) begin
      beat_d = beat_q + 1'b1;
    end else begin
      beat_d = beat_q;
    end
    vld_d = take && (beat_q == LAST_BEAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q     <= '0;
      desc_valid <= 1'b0;
    end else begin
      beat_q     <= beat_d;
      desc_valid <= vld_d;
    end
  end

  for (genvar g = 0; g < USED_WORDS; g++) begin : g_word
    logic [DW-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
      end else if (take && (beat_q == BEAT_W'(g))) begin
        w_q <= dret_data;
      end
    end
    assign words[g] = w_q;
  end

  assign desc = '{ctrl: words[0][DW-1:LEN_W],
                  len:  words[0][LEN_W-1:0],
                  src:  words[1],
                  dst:  words[2]};

  // R3: a complete descriptor needs four beats, so two never come back to back
  assert_beat_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid)
    else $error("descriptor completed on consecutive cycles");

  // R3: completion follows an accepted beat
  assert_beat_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(dret_valid && en))
    else $error("descriptor completed without a returned beat");
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DW-1:0]    base_i,
  input  logic             dfetch_ack,
  input  logic             desc_valid,
  input  desc_t            desc_i,
  input  logic             xfer_done,
  output logic             busy,
  output logic             recv_en,
  output logic             dfetch_req,
  output logic [DW-1:0]    dfetch_addr,
  output logic             xfer_start,
  output desc_t            xfer_desc,
  output logic             irq
);
  seq_state_e       st_q, st_d;
  logic [DW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;
  desc_t            cur_q, cur_d;
  logic             irq_d;
  logic             cmp;
  logic             cmp_notify;
  logic             cmp_last;
  logic             is_last;
  logic             cur_en;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    left_d     = left_q;
    cur_d      = cur_q;
    cur_en     = 1'b0;
    cmp        = 1'b0;
    cmp_notify = (st_q == ST_WAIT) ? cur_q.ctrl[CTL_NOTIFY] : desc_i.ctrl[CTL_NOTIFY];
    cmp_last   = (st_q == ST_WAIT) ? cur_q.ctrl[CTL_LAST]   : desc_i.ctrl[CTL_LAST];
    is_last    = (left_q == CNT_W'(1)) || cmp_last;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_d   = ST_REQ;
          addr_d = base_i;
          left_d = count_i;
        end
      end
      ST_REQ: begin
        if (dfetch_ack) st_d = ST_RECV;
      end
      ST_RECV: begin
        if (desc_valid) begin
          cur_d  = desc_i;
          cur_en = 1'b1;
          if (desc_i.len == '0) cmp = 1'b1;
          else st_d = ST_START;
        end
      end
      ST_START: st_d = ST_WAIT;
      ST_WAIT: begin
        if (xfer_done) cmp = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cmp) begin
      if (is_last) begin
        st_d = ST_IDLE;
      end else begin
        st_d   = ST_REQ;
        addr_d = addr_q + DW'(DESC_BYTES);
        left_d = left_q - 1'b1;
      end
    end
    irq_d = cmp && cmp_notify;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      irq    <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      irq    <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign recv_en     = (st_q == ST_RECV);
  assign dfetch_req  = (st_q == ST_REQ);
  assign dfetch_addr = addr_q;
  assign xfer_start  = (st_q == ST_START);
  assign xfer_desc   = cur_q;

  // R3: an unaccepted request keeps its address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dfetch_req && !dfetch_ack) |=> (dfetch_req && $stable(dfetch_addr)))
    else $error("fetch request dropped or moved before acceptance");

  // R4: the transfer launch lasts one cycle
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start)
    else $error("transfer start wider than one cycle");

  // R6: no zero-length transfer reaches the data mover
  assert_no_empty_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_desc.len != '0))
    else $error("zero-length descriptor launched a transfer");

  // R5: a follow-on fetch is raised only by a completion event
  assert_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dfetch_req) && $past(busy)) |-> ($past(xfer_done) || $past(desc_valid)))
    else $error("fetch issued while a descriptor was in flight");

  // R8: notification is a single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq)
    else $error("notification pulse wider than one cycle");

  // R9: a busy engine always has descriptors left
  assert_left_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0))
    else $error("busy with no descriptors left");
endmodule

// File: rtl/chain_dma_perf.sv
module chain_dma_perf #(
  parameter int PERF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              busy,
  output logic [PERF_W-1:0] cycles
);
  logic [PERF_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = launch || busy;
    if (launch) cnt_d = '0;
    else        cnt_d = cycles + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles <= '0;
    end else if (cnt_en) begin
      cycles <= cnt_d;
    end
  end

  // R10: one count per edge while a run is active
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch) |=> (cycles == ($past(cycles) + PERF_W'(1))))
    else $error("cycle counter missed an edge");

  // R10: the result holds once the run is over
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> $stable(cycles))
    else $error("cycle counter moved while idle");
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PERF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              dfetch_req,
  output logic [31:0]       dfetch_addr,
  input  logic              dfetch_ack,
  input  logic              dret_valid,
  input  logic [31:0]       dret_data,
  output logic              xfer_start,
  output logic [15:0]       xfer_len,
  output logic [15:0]       xfer_ctrl,
  output logic [31:0]       xfer_src,
  output logic [31:0]       xfer_dst,
  input  logic              xfer_done,
  output logic              irq,
  output logic              stat_busy,
  output logic              stat_err,
  output logic [PERF_W-1:0] stat_cycles
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             launch;
  logic [CNT_W-1:0] count;
  logic [DW-1:0]    base;
  logic             busy;
  logic             recv_en;
  logic             desc_valid;
  desc_t            desc;
  desc_t            xfer_desc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  chain_dma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .launch    (launch),
    .count     (count),
    .base      (base),
    .err       (stat_err)
  );

  chain_dma_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (recv_en),
    .dret_valid (dret_valid),
    .dret_data  (dret_data),
    .desc_valid (desc_valid),
    .desc       (desc)
  );

  chain_dma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .launch      (launch),
    .count_i     (count),
    .base_i      (base),
    .dfetch_ack  (dfetch_ack),
    .desc_valid  (desc_valid),
    .desc_i      (desc),
    .xfer_done   (xfer_done),
    .busy        (busy),
    .recv_en     (recv_en),
    .dfetch_req  (dfetch_req),
    .dfetch_addr (dfetch_addr),
    .xfer_start  (xfer_start),
    .xfer_desc   (xfer_desc),
    .irq         (irq)
  );

  chain_dma_perf #(.PERF_W(PERF_W)) u_perf (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .launch (launch),
    .busy   (busy),
    .cycles (stat_cycles)
  );

  assign stat_busy = busy;
  assign xfer_len  = xfer_desc.len;
  assign xfer_ctrl = xfer_desc.ctrl;
  assign xfer_src  = xfer_desc.src;
  assign xfer_dst  = xfer_desc.dst;

  // R3: every request targets a descriptor-aligned slot
  assert_fetch_aligned_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    dfetch_req |-> (dfetch_addr[ALIGN_W-1:0] == '0))
    else $error("descriptor fetch not aligned");
endmodule

// File: tb/sim_chain_dma_engine.sv
module sim_chain_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam int NDESC = 8;
  localparam int NRUN  = 6;

  // descriptor model: length (dwords) and control (bit0 notify, bit1 end of chain)
  localparam int LENS [NDESC] = '{4, 8, 0, 2, 3, 5, 1, 7};
  localparam int CTLS [NDESC] = '{1, 0, 1, 0, 2, 1, 0, 3};

  // run vectors: first index, count, fetch latency, transfer duration, expected fetches/starts/pulses
  localparam int RT_IDX [NRUN] = '{0, 1, 3, 5, 2, 6};
  localparam int RT_CNT [NRUN] = '{2, 3, 4, 2, 1, 3};
  localparam int RT_LAT [NRUN] = '{0, 2, 1, 3, 0, 4};
  localparam int RT_DUR [NRUN] = '{1, 3, 2, 5, 1, 2};
  localparam int RT_EF  [NRUN] = '{2, 3, 2, 2, 1, 2};
  localparam int RT_ES  [NRUN] = '{2, 2, 2, 2, 0, 2};
  localparam int RT_EI  [NRUN] = '{1, 1, 0, 1, 1, 1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        dfetch_req;
  logic [31:0] dfetch_addr;
  logic        dfetch_ack;
  logic        dret_valid;
  logic [31:0] dret_data;
  logic        xfer_start;
  logic [15:0] xfer_len;
  logic [15:0] xfer_ctrl;
  logic [31:0] xfer_src;
  logic [31:0] xfer_dst;
  logic        xfer_done;
  logic        irq;
  logic        stat_busy;
  logic        stat_err;
  logic [31:0] stat_cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int run_idx = 0;
  int fetch_k = 0;
  int starts = 0;
  int irqs = 0;
  int cur_idx = 0;
  int fetch_lat = 0;
  int xfer_dur = 1;
  int t0 = 0;
  bit xfer_open = 1'b0;
  bit irq_prev = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chain_dma_engine #(.CNT_W(16), .PERF_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dfetch_req(dfetch_req), .dfetch_addr(dfetch_addr), .dfetch_ack(dfetch_ack),
    .dret_valid(dret_valid), .dret_data(dret_data),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_ctrl(xfer_ctrl),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_done(xfer_done),
    .irq(irq), .stat_busy(stat_busy), .stat_err(stat_err), .stat_cycles(stat_cycles)
  );

  function automatic logic [31:0] mem_word(input int idx, input int w);
    case (w)
      0:       return {16'(CTLS[idx]), 16'(LENS[idx])};
      1:       return 32'hA000_0000 + 32'(idx * 256);
      2:       return 32'hB000_0000 + 32'(idx * 512);
      default: return 32'hFFFF_0000 | 32'(idx);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    reg_wr    = 1'b1;
    reg_sel   = sel;
    reg_wdata = data;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic launch(input int idx, input logic [31:0] raw_base, input int cnt,
                        input int lat, input int dur);
    run_idx   = idx;
    fetch_k   = 0;
    starts    = 0;
    irqs      = 0;
    fetch_lat = lat;
    xfer_dur  = dur;
    wr(2'd0, raw_base);
    t0 = cyc;
    wr(2'd1, 32'(cnt));
    chk(stat_busy == 1'b1, "R2 busy after launch", longint'(stat_busy), 1);
  endtask

  task automatic finish_run(input int ef, input int es, input int ei, input string tag);
    int held;
    while (stat_busy) @(negedge clk);
    chk(stat_cycles == 32'(cyc - t0 - 1), {"R10 run cycles ", tag},
        longint'(stat_cycles), longint'(cyc - t0 - 1));
    held = int'(stat_cycles);
    repeat (4) @(negedge clk);
    chk(stat_cycles == 32'(held), {"R10 cycles hold ", tag}, longint'(stat_cycles), longint'(held));
    chk(fetch_k == ef, {"R9 R7 fetch count ", tag}, longint'(fetch_k), longint'(ef));
    chk(starts == es, {"R6 start count ", tag}, longint'(starts), longint'(es));
    chk(irqs == ei, {"R8 pulse count ", tag}, longint'(irqs), longint'(ei));
  endtask

  // descriptor memory responder
  initial begin
    dfetch_ack = 1'b0;
    dret_valid = 1'b0;
    dret_data  = '0;
    forever begin
      @(negedge clk);
      if (dfetch_req && rst_n) begin
        chk(dfetch_addr == BASE + 32'(16 * (run_idx + fetch_k)), "R3 fetch address",
            longint'(dfetch_addr), longint'(BASE + 32'(16 * (run_idx + fetch_k))));
        chk(!xfer_open, "R5 fetch while transfer open", longint'(xfer_open), 0);
        cur_idx = run_idx + fetch_k;
        fetch_k++;
        dfetch_ack = 1'b1;
        @(negedge clk);
        dfetch_ack = 1'b0;
        repeat (fetch_lat) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          dret_valid = 1'b1;
          dret_data  = mem_word(cur_idx, b);
          @(negedge clk);
        end
        dret_valid = 1'b0;
      end
    end
  end

  // data mover responder
  initial begin
    xfer_done = 1'b0;
    forever begin
      @(negedge clk);
      if (xfer_start && rst_n) begin
        starts++;
        xfer_open = 1'b1;
        chk(LENS[cur_idx] != 0, "R6 zero length started", longint'(xfer_len), 0);
        chk(xfer_len == 16'(LENS[cur_idx]), "R4 length field", longint'(xfer_len), longint'(LENS[cur_idx]));
        chk(xfer_ctrl == 16'(CTLS[cur_idx]), "R4 control field", longint'(xfer_ctrl), longint'(CTLS[cur_idx]));
        chk(xfer_src == mem_word(cur_idx, 1), "R4 source field", longint'(xfer_src), longint'(mem_word(cur_idx, 1)));
        chk(xfer_dst == mem_word(cur_idx, 2), "R4 destination field", longint'(xfer_dst), longint'(mem_word(cur_idx, 2)));
        @(negedge clk);
        chk(xfer_start == 1'b0, "R4 start pulse width", longint'(xfer_start), 0);
        repeat (xfer_dur - 1) @(negedge clk);
        xfer_done = 1'b1;
        xfer_open = 1'b0;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  // notification monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irq) begin
        irqs++;
        if (irq_prev) chk(1'b0, "R8 pulse width", 2, 1);
      end
      irq_prev = irq;
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", longint'(stat_busy), 0);
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_sel   = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(stat_busy == 1'b0, "R1 busy", longint'(stat_busy), 0);
    chk(stat_err == 1'b0, "R1 err", longint'(stat_err), 0);
    chk(stat_cycles == 32'd0, "R1 cycles", longint'(stat_cycles), 0);
    chk(dfetch_req == 1'b0, "R1 fetch request", longint'(dfetch_req), 0);
    chk(xfer_start == 1'b0, "R1 start", longint'(xfer_start), 0);
    chk(irq == 1'b0, "R1 irq", longint'(irq), 0);

    // vector table of runs
    for (int r = 0; r < NRUN; r++) begin
      launch(RT_IDX[r], BASE + 32'(16 * RT_IDX[r]), RT_CNT[r], RT_LAT[r], RT_DUR[r]);
      finish_run(RT_EF[r], RT_ES[r], RT_EI[r], $sformatf("run%0d", r));
      chk(stat_err == 1'b0, "R11 no error on idle header", longint'(stat_err), 0);
    end

    // R2: zero count starts nothing
    fetch_k = 0;
    wr(2'd1, 32'd0);
    repeat (4) @(negedge clk);
    chk(stat_busy == 1'b0, "R2 zero count busy", longint'(stat_busy), 0);
    chk(fetch_k == 0, "R2 zero count fetch", longint'(fetch_k), 0);

    // R2: low base bits are dropped (0x3C aligns to slot 3)
    launch(3, BASE + 32'h3C, 1, 1, 2);
    finish_run(1, 1, 0, "unaligned base R2");

    // R11: header writes during a run are ignored and flagged
    launch(0, BASE, 2, 0, 20);
    repeat (2) @(negedge clk);
    wr(2'd0, BASE + 32'(16 * 5));
    wr(2'd1, 32'd1);
    chk(stat_err == 1'b1, "R11 error set", longint'(stat_err), 1);
    finish_run(2, 2, 1, "busy header R11");
    chk(stat_err == 1'b1, "R11 error sticky", longint'(stat_err), 1);
    wr(2'd2, 32'd1);
    chk(stat_err == 1'b0, "R11 error cleared", longint'(stat_err), 0);

    // R9: a following idle run uses the unchanged base path again
    launch(6, BASE + 32'(16 * 6), 1, 0, 1);
    finish_run(1, 1, 0, "single R9");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule